// File: doc/BRIEF.md
# Machine Check Status Register

This block keeps a record of asynchronous machine check events for a processor core and raises a machine check interrupt request. Error detection logic elsewhere in the core sends single-cycle strobes, one per cause: instruction bus read, data bus read, data bus write, translation-buffer parity, three cache error classes, and one implementation-specific class. When at least one strobe fires, the register sets a summary flag. In the same cycle it sets exactly one cause flag, the one with the highest priority.

Software reads the whole 32-bit word through a special-register read port. It acknowledges events through a write port that works as a clear mask. Each 1 in the written word clears the matching bit. Each 0 leaves the matching bit unchanged. The interrupt request is a level. It is high while the machine-check enable input from the machine state is set and the summary flag is set.

Bits are numbered with bit 0 as the most significant bit. Bit 0 is the summary flag. Bits 1 to 8 are cause flags. Bits 9 to 31 are reserved.

Top module: `mchk_status_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all 32 bits clear to 0 at that edge, so `sr_rd_data_o` reads 0 and `mc_irq_o` is 0.
- R2: A strobe on `err_strobe_i[k]` sets register bit k+1 and the summary bit 0 at the next rising edge. The cause bits are: bit 1 instruction bus read, bit 2 data bus read, bit 3 data bus write, bit 4 translation-buffer parity, bits 5 to 7 cache error classes, bit 8 the implementation-specific class.
- R3: When several strobes arrive in one cycle, only the cause bit with the lowest bit number is set, together with the summary bit.
- R4: A cause bit that is already set stays set when later events are recorded, until software clears it.
- R5: When `sr_wr_en_i` is high, each 1 in `sr_wr_mask_i` (bit 0 = MSB) clears the matching register bit at the next edge, and each 0 leaves that bit unchanged.
- R6: If a strobe and a clear of the same bit arrive in the same cycle, the bit ends up set. This applies to the summary bit and to the strobe's cause bit.
- R7: Bits 9 to 31 always read 0. Writes and strobes do not change them.
- R8: `mc_irq_o` is 1 only while `mc_enable_i` is 1 and the summary bit is 1. After a clear of the summary bit, it drops in the cycle that follows, even if cause bits are still set.
- R9: `sr_rd_data_o` always shows the full current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_strobe_i | input | 8 | Per-cause error strobes; index k maps to register bit k+1 |
| mc_enable_i | input | 1 | Machine-check enable from the machine state |
| sr_wr_en_i | input | 1 | Special-register write strobe |
| sr_wr_mask_i | input | 32 | Clear mask, bit 0 is the MSB |
| sr_rd_data_o | output | 32 | Current register contents, bit 0 is the MSB |
| mc_irq_o | output | 1 | Machine check interrupt request level |

## Verification
Each cause strobe is driven on its own. This shows whether every strobe lands on the right bit position. Groups of strobes in the same cycle show whether the priority selection chooses the lowest bit number and drops the others. A strobe that arrives after a cause bit is already set separates sticky behaviour from overwrite. Masks with mixed ones and zeros, including masks with ones in the reserved bits, separate clearing from loading. A strobe in the same cycle as a clear of the same bit shows which of the two wins. Toggling the enable input and clearing only the summary bit shows whether the interrupt follows the summary flag or the cause flags.

// File: rtl/mchk_pkg.sv
// Shared sizes for the machine check status register.
// Assumes bit 0 (summary) is the most significant bit of the word.
package mchk_pkg;
    parameter int unsigned MC_REG_W   = 32;   // architected register width
    parameter int unsigned MC_NCAUSE  = 8;    // cause flags at bits 1..MC_NCAUSE
    parameter int unsigned MC_SUM_BIT = 0;    // summary flag position
endpackage

// File: rtl/mchk_prio_pick.sv
// Fixed-priority picker: index 0 has the highest priority.
// Assumes requests are single-cycle strobes; purely combinational.
module mchk_prio_pick #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    // seen[k] is high when some request below index k is active
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar k = 0; k < N; k++) begin : g_chain
        assign grant_o[k]  = req_i[k] & ~seen[k];
        assign seen[k + 1] = seen[k] | req_i[k];
    end

    assign any_o = seen[N];
endmodule

// File: rtl/mchk_bit_update.sv
// Per-bit storage for the status word: set beats clear, reserved bits read 0.
// Assumes bit 0 is the MSB and live bits are 0..NCAUSE.
module mchk_bit_update #(
    parameter int unsigned W      = 32,
    parameter int unsigned NCAUSE = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [0:W-1] set_i,
    input  logic [0:W-1] clr_i,
    output logic [0:W-1] q_o
);
    localparam int unsigned LIVE = NCAUSE + 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b < LIVE) begin : g_live
            logic q;
            // hold, clear on mask, set on event; set has precedence
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= 1'b0;
                else if (set_i[b]) q <= 1'b1;
                else if (clr_i[b]) q <= 1'b0;
            end
            assign q_o[b] = q;
        end else begin : g_rsvd
            // reserved position: inputs reach no storage and the bit reads 0
            assign q_o[b] = set_i[b] & clr_i[b] & 1'b0;
        end
    end
endmodule

// File: rtl/mchk_irq_gen.sv
// Interrupt request level: enable qualified by the summary flag.
// Assumes both inputs are already synchronous to the core clock.
module mchk_irq_gen (
    input  logic enable_i,
    input  logic summary_i,
    output logic irq_o
);
    assign irq_o = enable_i & summary_i;
endmodule

// File: rtl/mchk_status_reg.sv
// Machine check status register top: records the highest-priority error
// strobe with a summary flag, gives software a clear-mask write and a full read.
// Assumes error strobes last one cycle and the enable is synchronous.
module mchk_status_reg
    import mchk_pkg::*;
#(
    parameter int unsigned REG_W  = MC_REG_W,
    parameter int unsigned NCAUSE = MC_NCAUSE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCAUSE-1:0] err_strobe_i,
    input  logic             mc_enable_i,
    input  logic             sr_wr_en_i,
    input  logic [0:REG_W-1] sr_wr_mask_i,
    output logic [0:REG_W-1] sr_rd_data_o,
    output logic             mc_irq_o
);
    localparam int unsigned SUM = MC_SUM_BIT;

    logic [NCAUSE-1:0] grant;
    logic              any_evt;
    logic [0:REG_W-1]  set_vec;
    logic [0:REG_W-1]  clr_vec;
    logic [0:REG_W-1]  stat_q;

    mchk_prio_pick #(.N(NCAUSE)) u_pick (
        .req_i   (err_strobe_i),
        .grant_o (grant),
        .any_o   (any_evt)
    );

    // build the set vector: summary plus the chosen cause position
    always_comb begin
        set_vec      = '0;
        set_vec[SUM] = any_evt;
        for (int k = 0; k < NCAUSE; k++) set_vec[k + 1] = grant[k];
    end

    // a write is a clear mask, gated by the write strobe
    assign clr_vec = sr_wr_en_i ? sr_wr_mask_i : '0;

    mchk_bit_update #(.W(REG_W), .NCAUSE(NCAUSE)) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q_o   (stat_q)
    );

    assign sr_rd_data_o = stat_q;

    mchk_irq_gen u_irq (
        .enable_i  (mc_enable_i),
        .summary_i (stat_q[SUM]),
        .irq_o     (mc_irq_o)
    );
endmodule

// File: rtl/mchk_status_reg_chk.sv
// Checker for the machine check status register, bound to the top module.
// Observes ports only.
module mchk_status_reg_chk #(
    parameter int unsigned REG_W  = 32,
    parameter int unsigned NCAUSE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCAUSE-1:0] err_strobe_i,
    input logic              mc_enable_i,
    input logic              sr_wr_en_i,
    input logic [0:REG_W-1]  sr_wr_mask_i,
    input logic [0:REG_W-1]  sr_rd_data_o,
    input logic              mc_irq_o
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (sr_rd_data_o == '0));

    // R2
    strobe_sets_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe_i != '0) |=> sr_rd_data_o[0]);

    // R3
    one_new_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe_i != '0) |=>
        ($countones(sr_rd_data_o[1:NCAUSE] & ~$past(sr_rd_data_o[1:NCAUSE])) <= 1));

    // R4
    sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_wr_en_i && sr_rd_data_o[1]) |=> sr_rd_data_o[1]);

    // R5
    mask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en_i && sr_wr_mask_i[0] && err_strobe_i == '0) |=> !sr_rd_data_o[0]);

    // R6
    top_prio_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe_i[0] |=> sr_rd_data_o[1]);

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_rd_data_o[NCAUSE+1:REG_W-1] == '0);

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_irq_o |-> (mc_enable_i && sr_rd_data_o[0]));

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_rd_data_o[0]) |-> !mc_irq_o);
endmodule

bind mchk_status_reg mchk_status_reg_chk #(.REG_W(REG_W), .NCAUSE(NCAUSE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_strobe_i (err_strobe_i),
    .mc_enable_i  (mc_enable_i),
    .sr_wr_en_i   (sr_wr_en_i),
    .sr_wr_mask_i (sr_wr_mask_i),
    .sr_rd_data_o (sr_rd_data_o),
    .mc_irq_o     (mc_irq_o)
);

// File: tb/mchk_status_reg_tb_top.sv
// Scoreboard bench: the driver predicts each cycle's result into a queue,
// and the monitor compares it after the clock edge.
module mchk_status_reg_tb_top;
    localparam int W  = 32;
    localparam int NC = 8;

    typedef struct {
        logic [0:W-1] data;
        logic         irq;
        string        tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   strobe = '0;
    logic            en = 1'b0;
    logic            wr = 1'b0;
    logic [0:W-1]    mask = '0;
    logic [0:W-1]    rd;
    logic            irq;

    logic [0:W-1]    model = '0;
    exp_t            q[$];
    int              total = 0;
    int              bad = 0;
    bit              done = 1'b0;

    always #5 clk = ~clk;

    mchk_status_reg dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_strobe_i (strobe),
        .mc_enable_i  (en),
        .sr_wr_en_i   (wr),
        .sr_wr_mask_i (mask),
        .sr_rd_data_o (rd),
        .mc_irq_o     (irq)
    );

    // driver: apply one cycle of stimulus and push the predicted result
    task automatic step(input logic r, input logic [NC-1:0] s, input logic e,
                        input logic w, input logic [0:W-1] m, input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = r; strobe = s; en = e; wr = w; mask = m;
        if (!r) model = '0;
        else begin
            if (w) model = model & ~m;
            for (int k = 0; k < NC; k++) begin
                if (s[k]) begin
                    model[k + 1] = 1'b1;
                    model[0]     = 1'b1;
                    break;
                end
            end
            model[NC+1:W-1] = '0;
        end
        it.data = model;
        it.irq  = e & model[0];
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic idle(input logic e, input string tag);
        step(1'b1, '0, e, 1'b0, '0, tag);
    endtask

    task automatic clr(input logic [0:W-1] m, input logic e, input string tag);
        step(1'b1, '0, e, 1'b1, m, tag);
    endtask

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                total++;
                if (rd !== it.data) begin
                    bad++;
                    $display("FAIL %s data act=%h exp=%h", it.tag, rd, it.data);
                end
                total++;
                if (irq !== it.irq) begin
                    bad++;
                    $display("FAIL %s irq act=%b exp=%b", it.tag, irq, it.irq);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset clears everything
        step(1'b0, '0, 1'b1, 1'b0, '0, "R1");
        step(1'b0, 8'hFF, 1'b1, 1'b1, '1, "R1");
        idle(1'b1, "R1");

        // R2, R9: each cause alone lands on its own bit
        for (int k = 0; k < NC; k++) begin
            step(1'b1, NC'(1) << k, 1'b1, 1'b0, '0, "R2");
            idle(1'b1, "R9");
            clr('1, 1'b1, "R5");
        end

        // R3: several strobes, lowest bit number wins
        step(1'b1, 8'b0110_0000, 1'b0, 1'b0, '0, "R3");
        clr('1, 1'b0, "R5");
        step(1'b1, 8'b1000_1100, 1'b0, 1'b0, '0, "R3");
        clr('1, 1'b0, "R5");
        step(1'b1, 8'hFF, 1'b0, 1'b0, '0, "R3");
        clr('1, 1'b0, "R5");

        // R4: earlier causes stay set
        step(1'b1, 8'b0000_0100, 1'b0, 1'b0, '0, "R4");
        step(1'b1, 8'b0001_0000, 1'b0, 1'b0, '0, "R4");
        step(1'b1, 8'b0000_0001, 1'b0, 1'b0, '0, "R4");
        idle(1'b0, "R4");

        // R5: partial mask clears only the ones
        clr(32'h2000_0000, 1'b0, "R5");
        clr(32'h0800_0000, 1'b0, "R5");
        clr(32'h0000_0000, 1'b0, "R5");
        step(1'b1, '0, 1'b0, 1'b1, 32'h4000_0000, "R5");
        clr('1, 1'b0, "R5");

        // R6: set beats clear in the same cycle
        step(1'b1, 8'b0000_0010, 1'b1, 1'b1, '1, "R6");
        step(1'b1, 8'b0000_0010, 1'b1, 1'b1, 32'hA000_0000, "R6");
        clr('1, 1'b1, "R5");

        // R7: reserved bits stay zero
        clr(32'h007F_FFFF, 1'b0, "R7");
        step(1'b1, 8'h80, 1'b0, 1'b1, 32'h007F_FFFF, "R7");
        clr('1, 1'b0, "R7");

        // R8: interrupt follows enable and summary only
        step(1'b1, 8'b0000_1000, 1'b0, 1'b0, '0, "R8");
        idle(1'b1, "R8");
        idle(1'b0, "R8");
        idle(1'b1, "R8");
        clr(32'h8000_0000, 1'b1, "R8");
        idle(1'b1, "R8");
        clr('1, 1'b1, "R8");

        // R1: reset with live state
        step(1'b1, 8'h01, 1'b1, 1'b0, '0, "R2");
        step(1'b0, '0, 1'b1, 1'b0, '0, "R1");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule